// File: doc/BRIEF.md
# Dual-Mode Serial EEPROM Slave

This block models a small serial memory. It has two ways of working. After reset it is in transmit-only mode. In that mode each rising edge of the auxiliary clock input `vclk_i` puts the next stored bit on the data line, most significant bit first. Every ninth clock is a released slot between bytes. The byte address starts at zero and wraps at the end of the array.

When a bus master issues a START and then raises SCL, the block switches to bidirectional mode and stays there until reset. In bidirectional mode it behaves as an I2C slave:
- It answers device addresses of the form `1010xxx`.
- It takes a one-byte word address.
- It accepts data bytes, which are stored only while `vclk_i` is high.
- It returns bytes sequentially.

A STOP that ends a write which stored at least one byte starts a modelled programming cycle. The cycle lasts `WR_CYCLES` system clocks, and the block ignores the bus until it ends.

All bus inputs are synchronised to `clk` and edge-detected there. The data line is driven as an open-drain enable: `sda_oe_o` high means pull SDA low. The surrounding logic must sample SCL and SDA at least several system clocks per bus quarter-period.

Top module: `dualmode_eeprom`

## Requirements
- R1: After reset the block is in transmit-only mode, `sda_oe_o` is low, and byte `i` of the array holds `i XOR 8'h5A`.
- R2: In transmit-only mode, each rising edge of `vclk_i` drives one bit of the current byte onto SDA, MSB first, starting from address 0. The ninth edge releases SDA and advances the address, which wraps from 127 to 0.
- R3: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. The first SCL rise after a START moves the block permanently into bidirectional mode. From then on, `vclk_i` edges no longer drive SDA.
- R4: An address byte whose upper four bits are `1010` is acknowledged by pulling SDA low during the ninth SCL pulse. Bit 0 = 1 means read and bit 0 = 0 means write. Any other address is not acknowledged, and the block ignores the bus until the next START.
- R5: After a write address, the next byte sets the word address (bits 6:0). Every following data byte is acknowledged, stored at the current address when `vclk_i` is high at its acknowledge, and the address then increments.
- R6: A data byte received while `vclk_i` is low is still acknowledged. Memory is left unchanged, and the following STOP starts no programming cycle.
- R7: A STOP that ends a write that stored a byte starts a programming cycle of `WR_CYCLES` clocks. During that cycle START conditions are ignored and SDA stays released, so an address is not acknowledged.
- R8: A read returns bytes from the current address, MSB first. The block continues while the master acknowledges and stops at a master NACK. The address increments after each byte and wraps from 127 to 0.
- R9: A write address and word address followed by a repeated START and a read address returns the byte at that word address.
- R10: The block only pulls SDA low or releases it. In bidirectional mode `sda_oe_o` changes only while SCL is low, or at a START or STOP.
- R11: After a STOP that ends a read, the block is idle and acknowledges no byte until a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| vclk_i | input | 1 | Write enable in bidirectional mode, shift clock in transmit-only mode |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The embedded assertions watch, on every cycle:
- that SDA only moves while SCL is low or at a bus condition (R10);
- that the line stays released and START is ignored during a programming cycle, and that such a cycle only ever begins at a STOP (R7);
- that the transmit-only output changes only after a `vclk_i` edge;
- that stores happen only with `vclk_i` high;
- that the mode never reverts.

Only the bench scenarios can show the data-level behaviour: stored bytes coming out in the right order with address wrap, address matching, write gating by `vclk_i`, a NACK to a probe sent during the programming cycle, and sequential and random reads returning what was written.

// File: rtl/dme_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the bidirectional-mode state type.
// Assumes 8-bit data bytes throughout.
package dme_pkg;
    localparam int          BYTE_W  = 8;
    localparam logic [3:0]  DEV_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } bus_state_t;
endpackage

// File: rtl/dme_sampler.sv
`timescale 1ns/1ps
// dme_sampler: synchronises SCL, SDA and VCLK into the clk domain and
// derives edge and bus-condition pulses, each one clk wide.
// Assumes SYNC_STAGES >= 2 and bus edges far slower than clk.
module dme_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic vclk_i,
    output logic scl_s,
    output logic sda_s,
    output logic vclk_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic vclk_rise,
    output logic start_det,
    output logic stop_det
);
    localparam int         NCH      = 3;
    localparam logic [2:0] IDLE_LVL = 3'b011; // vclk low, sda/scl high

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] cur;
    logic [NCH-1:0] prev;

    assign raw_in = {vclk_i, sda_i, scl_i};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift each line through its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {SYNC_STAGES{IDLE_LVL[ch]}};
            else        chain <= {chain[SYNC_STAGES-2:0], raw_in[ch]};
        end
        assign cur[ch] = chain[SYNC_STAGES-1];
    end

    // Hold last cycle's synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= cur;
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign vclk_s    = cur[2];
    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign vclk_rise = cur[2] & ~prev[2];
    assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/dme_store.sv
`timescale 1ns/1ps
// dme_store: register-file byte array with one write port and two
// asynchronous read ports. Reset loads byte i with i XOR INIT_XOR.
// Assumes DEPTH is a power of two so addresses wrap naturally.
module dme_store #(
    parameter int         DEPTH    = 128,
    parameter logic [7:0] INIT_XOR = 8'h5A,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    // Initialise the array on reset, otherwise perform gated writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ INIT_XOR;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dme_txonly.sv
`timescale 1ns/1ps
// dme_txonly: transmit-only streamer. Each VCLK rise drives the next
// bit MSB first; the ninth rise releases SDA and advances the address.
// Assumes it is held idle (en low) once the block leaves this mode.
module dme_txonly #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          vclk_rise,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] tptr,
    output logic          oe
);
    logic [3:0] pos;
    logic [2:0] bsel;

    assign bsel = 3'd7 - pos[2:0];

    // Step through bit slots on each VCLK rise while the mode is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            tptr <= '0;
            oe   <= 1'b0;
        end else if (!en) begin
            oe <= 1'b0;
        end else if (vclk_rise) begin
            if (pos == 4'd8) begin
                oe   <= 1'b0;
                pos  <= '0;
                tptr <= tptr + 1'b1;
            end else begin
                oe  <= ~rdata[bsel];
                pos <= pos + 1'b1;
            end
        end
    end

    // R2: output moves only in response to a VCLK edge while active.
    a_r2_vclk_paced: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && (oe != $past(oe))) |-> $past(vclk_rise));
endmodule

// File: rtl/dme_bus_fsm.sv
`timescale 1ns/1ps
// dme_bus_fsm: bidirectional-mode slave. Tracks START/STOP, matches the
// device tag, loads the word pointer, gates stores with VCLK, streams
// reads and times the programming cycle. Assumes edge pulses come from
// dme_sampler; oe is masked outside bidirectional mode by the top.
module dme_bus_fsm
    import dme_pkg::*;
#(
    parameter int AW        = 7,
    parameter int WR_CYCLES = 400,
    localparam int CW       = $clog2(WR_CYCLES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          vclk_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          oe,
    output logic          busy
);
    bus_state_t state, nxt;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic [7:0]    tx;
    logic          acking;
    logic          more;
    logic          wrote;
    logic [CW-1:0] busy_cnt;
    logic [2:0]    bsel;

    assign bsel = 3'd7 - cnt[2:0];
    assign busy = (state == ST_BUSY);

    // Main protocol sequencer: bus conditions first, then per-state work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            acking    <= 1'b0;
            more      <= 1'b0;
            wrote     <= 1'b0;
            busy_cnt  <= '0;
            ptr       <= '0;
            oe        <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (state == ST_BUSY) begin
                oe <= 1'b0;
                if (busy_cnt == CW'(WR_CYCLES - 1)) begin
                    state    <= ST_IDLE;
                    busy_cnt <= '0;
                end else begin
                    busy_cnt <= busy_cnt + 1'b1;
                end
            end else if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                acking <= 1'b0;
                oe     <= 1'b0;
            end else if (stop_det) begin
                cnt    <= '0;
                acking <= 1'b0;
                oe     <= 1'b0;
                wrote  <= 1'b0;
                state  <= wrote ? ST_BUSY : ST_IDLE;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && !acking && cnt < 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && acking) begin
                            acking <= 1'b0;
                            cnt    <= '0;
                            state  <= nxt;
                            if (nxt == ST_RDATA) begin
                                tx <= rdata;
                                oe <= ~rdata[7];
                            end else begin
                                oe <= 1'b0;
                            end
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:4] == DEV_TAG) begin
                                    oe     <= 1'b1;
                                    acking <= 1'b1;
                                    nxt    <= shreg[0] ? ST_RDATA : ST_WADDR;
                                end else begin
                                    state <= ST_IDLE;
                                    cnt   <= '0;
                                end
                            end else if (state == ST_WADDR) begin
                                ptr    <= shreg[AW-1:0];
                                oe     <= 1'b1;
                                acking <= 1'b1;
                                nxt    <= ST_WDATA;
                            end else begin
                                oe     <= 1'b1;
                                acking <= 1'b1;
                                nxt    <= ST_WDATA;
                                ptr    <= ptr + 1'b1;
                                if (vclk_s && en) begin
                                    mem_we    <= 1'b1;
                                    mem_waddr <= ptr;
                                    mem_wdata <= shreg;
                                    wrote     <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                oe    <= 1'b0;
                                ptr   <= ptr + 1'b1;
                                cnt   <= '0;
                                state <= ST_RACK;
                            end else begin
                                oe <= ~tx[bsel];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            more <= ~sda_s;
                        end else if (scl_fall) begin
                            if (more) begin
                                tx    <= rdata;
                                oe    <= ~rdata[7];
                                cnt   <= '0;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: oe <= 1'b0;
                endcase
            end
        end
    end

    // R10: SDA drive moves only while SCL is low or at a bus condition.
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (oe != $past(oe)) |-> (!$past(scl_s) || $past(start_det || stop_det)));
    // R7: the line stays released throughout a programming cycle.
    a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !oe);
    // R7: a programming cycle only begins at a STOP.
    a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));
    // R7: START does not break into a running programming cycle.
    a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_det && busy_cnt != CW'(WR_CYCLES - 1)) |=> busy);
    // R5: a store only follows a cycle where VCLK was high.
    a_r5_store_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(vclk_s));
endmodule

// File: rtl/dualmode_eeprom.sv
`timescale 1ns/1ps
// dualmode_eeprom: top level. Samples the bus, selects transmit-only or
// bidirectional operation, and drives SDA as an open-drain enable.
// Assumes MEM_DEPTH is a power of two and the bus runs well below clk.
module dualmode_eeprom #(
    parameter int         MEM_DEPTH   = 128,
    parameter int         WR_CYCLES   = 400,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] INIT_XOR    = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic vclk_i,
    output logic sda_oe_o
);
    localparam int AW = $clog2(MEM_DEPTH);

    logic scl_s, sda_s, vclk_s;
    logic scl_rise, scl_fall, vclk_rise, start_det, stop_det;
    logic bidir, armed;
    logic tx_oe, bus_oe, bus_busy;
    logic mem_we;
    logic [AW-1:0] tptr, bptr, mem_waddr;
    logic [7:0]    tx_rdata, bus_rdata, mem_wdata;

    dme_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .vclk_i(vclk_i), .scl_s(scl_s), .sda_s(sda_s), .vclk_s(vclk_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .vclk_rise(vclk_rise),
        .start_det(start_det), .stop_det(stop_det)
    );

    dme_store #(.DEPTH(MEM_DEPTH), .INIT_XOR(INIT_XOR)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr_a(tptr), .rdata_a(tx_rdata),
        .raddr_b(bptr), .rdata_b(bus_rdata)
    );

    dme_txonly #(.AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(!bidir), .vclk_rise(vclk_rise),
        .rdata(tx_rdata), .tptr(tptr), .oe(tx_oe)
    );

    dme_bus_fsm #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_bus (
        .clk(clk), .rst_n(rst_n), .en(bidir), .scl_s(scl_s), .sda_s(sda_s),
        .vclk_s(vclk_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rdata(bus_rdata),
        .ptr(bptr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .oe(bus_oe), .busy(bus_busy)
    );

    // Arm on START, disarm on STOP; latch bidirectional mode on SCL rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            bidir <= 1'b0;
        end else begin
            if (start_det)     armed <= 1'b1;
            else if (stop_det) armed <= 1'b0;
            if (armed && scl_rise) bidir <= 1'b1;
        end
    end

    assign sda_oe_o = bidir ? bus_oe : tx_oe;

    // R3: once bidirectional, the block never returns to transmit-only.
    a_r3_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bidir) |-> bidir);
    // R7: no drive from the block during a programming cycle.
    a_r7_top_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir && bus_busy) |-> !sda_oe_o);
endmodule

// File: tb/dualmode_eeprom_test.sv
`timescale 1ns/1ps
module dualmode_eeprom_test;
    localparam int         Q      = 10;    // clk cycles per bus quarter bit
    localparam int         WR_CYC = 400;
    localparam logic [7:0] XORV   = 8'h5A;

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] data;
        logic       gate;
    } vec_t;
    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{7'h10, 8'hC3, 1'b1}, '{7'h7F, 8'h3C, 1'b1}, '{7'h00, 8'h99, 1'b0},
        '{7'h45, 8'h12, 1'b1}, '{7'h45, 8'hEE, 1'b0}, '{7'h22, 8'h00, 1'b1}};

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, vclk = 1'b0;
    logic sda_oe, sda_line;
    int   checks = 0, errors = 0;
    logic [7:0] model [128];

    assign sda_line = m_sda & ~sda_oe;
    always #2.5 clk = ~clk;

    dualmode_eeprom uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                         .vclk_i(vclk), .sda_oe_o(sda_oe));

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
        end
        m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = ~sda_line; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
        end
        m_sda = ~mack; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q); m_sda = 1'b1;
    endtask

    task automatic vpulse(output logic bitv);
        vclk = 1'b1; wt(8); bitv = sda_line; vclk = 1'b0; wt(8);
    endtask

    task automatic rand_read(input logic [6:0] a, output logic [7:0] b, output logic acks);
        logic k0, k1, k2;
        bus_start(); send_byte(8'hA0, k0); send_byte({1'b0, a}, k1);
        bus_start(); send_byte(8'hA1, k2); recv_byte(1'b0, b); bus_stop();
        acks = k0 & k1 & k2;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic k, k2, nb;
        logic [7:0] b;
        for (int i = 0; i < 128; i++) model[i] = 8'(i) ^ XORV;
        wt(10); rst_n = 1'b1; wt(2);
        chk("R1 released after reset", sda_oe, 0);

        // R1/R2: stream 129 bytes in transmit-only mode, checking the wrap.
        for (int n = 0; n < 129; n++) begin
            for (int i = 7; i >= 0; i--) begin vpulse(nb); b[i] = nb; end
            vpulse(nb);
            if (n == 0 || n == 127 || n == 128) chk("R2 null slot released", nb, 1);
            chk(n == 128 ? "R2 wrap to byte 0" : "R1/R2 streamed byte", b, model[n % 128]);
        end

        // R3: START plus SCL activity switches mode; read current address 0.
        bus_start(); send_byte(8'hA1, k);
        chk("R3 switch and R4 read address ack", k, 1);
        recv_byte(1'b0, b); bus_stop();
        chk("R8 current-address read", b, model[0]);
        nb = 1'b1;
        for (int i = 0; i < 9; i++) begin
            vclk = 1'b1; wt(8); nb = nb & sda_line; vclk = 1'b0; wt(8);
        end
        chk("R3 vclk ignored in bidir mode", nb, 1);

        // Vector table: write under VCLK gate, then random read back.
        for (int v = 0; v < NVEC; v++) begin
            vclk = VECS[v].gate;
            bus_start(); send_byte(8'hA0, k); send_byte({1'b0, VECS[v].addr}, k2);
            chk("R4/R5 address and word ack", k & k2, 1);
            send_byte(VECS[v].data, k);
            chk(VECS[v].gate ? "R5 data ack" : "R6 data ack with vclk low", k, 1);
            bus_stop(); vclk = 1'b0;
            if (VECS[v].gate) begin
                model[VECS[v].addr] = VECS[v].data;
                wt(WR_CYC + 40);
            end
            rand_read(VECS[v].addr, b, k);
            chk("R9 random read acks", k, 1);
            chk(VECS[v].gate ? "R5/R9 read back" : "R6 memory unchanged", b, model[VECS[v].addr]);
        end

        // R7: probe during the programming cycle is not acknowledged.
        vclk = 1'b1;
        bus_start(); send_byte(8'hA0, k); send_byte(8'h30, k); send_byte(8'h77, k);
        chk("R10 line released after ack", sda_oe, 0);
        bus_stop(); vclk = 1'b0; model[8'h30] = 8'h77;
        bus_start(); send_byte(8'hA0, k);
        chk("R7 no ack while programming", k, 0);
        bus_stop(); wt(WR_CYC + 40);
        rand_read(7'h30, b, k);
        chk("R7 data committed after cycle", b, 8'h77);

        // R6: gated-off write starts no programming cycle.
        bus_start(); send_byte(8'hA0, k); send_byte(8'h31, k); send_byte(8'h11, k);
        bus_stop();
        bus_start(); send_byte(8'hA0, k);
        chk("R6 no busy after gated write", k, 1);
        bus_stop();
        rand_read(7'h31, b, k);
        chk("R6 memory unchanged at 0x31", b, model[8'h31]);

        // R4: mismatched address, then a byte without START.
        bus_start(); send_byte(8'h92, k);
        chk("R4 foreign address not acked", k, 0);
        send_byte(8'hA0, k);
        chk("R4 ignored until next START", k, 0);
        bus_stop();

        // R8: sequential read across the wrap.
        bus_start(); send_byte(8'hA0, k); send_byte(8'h7E, k);
        bus_start(); send_byte(8'hA1, k);
        recv_byte(1'b1, b); chk("R8 seq byte 0x7E", b, model[8'h7E]);
        recv_byte(1'b1, b); chk("R8 seq byte 0x7F", b, model[8'h7F]);
        recv_byte(1'b0, b); chk("R8 seq wrap to 0", b, model[0]);
        bus_stop();

        // R11: after a read and STOP, no ack without START.
        send_byte(8'hA0, k);
        chk("R11 no response without START", k, 0);
        bus_stop();
        bus_start(); send_byte(8'hA1, k); recv_byte(1'b0, b); bus_stop();
        chk("R8 current address continues", b, model[1]);

        summary();
    end
endmodule